// File: doc/BRIEF.md
# UART Divisor Latch and Baud Tick Generator

This block is the rate-setting slice of a 16550-style UART. It stores a 16-bit baud divisor in two byte registers, a low byte and a high byte. From the serial clock it produces a 16x oversampling tick at one tick per divisor clocks, so each serial bit spans 16 ticks. It also stores the interrupt-enable byte. That byte lives at the same word offset as the divisor high byte. A latch-select input, driven from bit 7 of the line control register elsewhere, decides which of the two the offset reaches.

Software reaches the block through a simple write strobe with an address and a byte of data, plus a combinational read-data word. Divisor writes are refused while the UART reports itself busy. Writing the high byte opens an eight-cycle settling window, and a not-ready flag is raised for that window so the transfer logic can hold off. A divisor of zero stops the tick completely.

Top module: `uart_baud_regs`

## Requirements
- R1: Out of a synchronous active-low reset, both divisor bytes and the interrupt-enable byte are zero, `baud_tick` is low, `settle_pending` is low and every readable offset returns zero.
- R2: When `latch_sel` is 1, a write to offset 0x00 sets the divisor low byte and a write to offset 0x04 sets the divisor high byte. When `latch_sel` is 0, a write to offset 0x04 sets the interrupt-enable byte and a write to offset 0x00 changes nothing. Writes to any other offset change nothing.
- R3: A divisor write made while `uart_busy` is 1 leaves both divisor bytes unchanged. Interrupt-enable writes are not gated by `uart_busy`.
- R4: With a non-zero divisor D, `baud_tick` is high for exactly one cycle in every D cycles. D = 1 holds it high on every cycle.
- R5: While the full 16-bit divisor is zero, `baud_tick` stays low.
- R6: An accepted write of the divisor high byte holds `settle_pending` high for the 8 cycles that follow the write edge, and then drops it. A further accepted high-byte write restarts the 8 cycles.
- R7: The `irq_en` output mirrors the interrupt-enable byte. The bits are: bit 0 received-data enable, bit 1 transmit-holding-empty enable, bit 2 receiver line status enable (highest priority), bit 3 modem status enable (fourth priority), and bit 7 programmable transmit-empty mode enable.
- R8: Interrupt-enable bits 6:4 ignore writes and read as zero. Bits 31:8 of `bus_rdata` are always zero.
- R9: Any accepted divisor byte write restarts the tick phase. Counting from the cycle that follows the write edge as cycle 1, the first tick appears in cycle D of the new divisor.
- R10: `bus_rdata` is combinational. Offset 0x00 returns the low byte when `latch_sel` is 1 and zero otherwise. Offset 0x04 returns the high byte when `latch_sel` is 1 and the interrupt-enable byte when it is 0. Unmapped offsets return zero. All of these follow `latch_sel` and `bus_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| latch_sel | input | 1 | 1 selects the divisor bytes, 0 selects the interrupt-enable byte |
| uart_busy | input | 1 | 1 refuses divisor writes |
| baud_tick | output | 1 | 16x oversampling tick, one cycle wide |
| settle_pending | output | 1 | High during the settling window after a high-byte write |
| irq_en | output | 8 | Current interrupt-enable byte |

## Verification
Register writes take effect at the edge that samples `bus_wr`. The stored value, `irq_en` and the read data show the new contents in the cycle right after that edge. `settle_pending` rises in that same following cycle and stays up for eight cycles. The first tick after a divisor write comes D cycles after the write edge, and ticks then repeat every D cycles. `bus_rdata` has no register in its path, so it follows `latch_sel` and `bus_addr` without delay. The bench drives inputs on the falling edge. It steps a behavioural model at each rising edge and compares all outputs one nanosecond later, so every result is checked in exactly the cycle it is due.

// File: rtl/uart_baud_pkg.sv
// Package: shared constants for the UART divisor/baud slice.
// Assumes byte-wide registers at word offsets, as in a 16550-style map.
package uart_baud_pkg;
    localparam int ADDR_W        = 8;
    localparam int REG_W         = 8;
    localparam int RDATA_W       = 32;
    localparam int DIV_W         = 2 * REG_W;
    localparam int SETTLE_CYCLES = 8;

    localparam logic [ADDR_W-1:0] OFS_DIV_LO = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SHARED = 8'h04;

    // Bit positions of the interrupt-enable byte
    localparam int IE_RXDATA = 0;
    localparam int IE_TXEMPTY = 1;
    localparam int IE_LINESTAT = 2;
    localparam int IE_MODEM = 3;
    localparam int IE_PTHRE = 7;

    localparam logic [REG_W-1:0] IE_WRITABLE =
        (REG_W'(1) << IE_RXDATA) | (REG_W'(1) << IE_TXEMPTY) |
        (REG_W'(1) << IE_LINESTAT) | (REG_W'(1) << IE_MODEM) |
        (REG_W'(1) << IE_PTHRE);
endpackage

// File: rtl/uart_div_regs.sv
// Module: register storage and decode for the divisor bytes and the
// interrupt-enable byte, including the read multiplexer.
// Assumes: latch_sel comes from the line control register elsewhere;
// read path is combinational from the stored values.
module uart_div_regs
    import uart_baud_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    input  logic               latch_sel,
    input  logic               uart_busy,
    output logic [DIV_W-1:0]   divisor,
    output logic [REG_W-1:0]   ie_reg,
    output logic               div_wr_ok,
    output logic               hi_wr_ok,
    output logic [RDATA_W-1:0] bus_rdata
);
    logic [REG_W-1:0] div_lo, div_hi;
    logic             lo_wr_ok, ie_wr_ok;

    // Decode which storage a write is allowed to touch this cycle
    always_comb begin
        lo_wr_ok  = bus_wr && latch_sel && !uart_busy && (bus_addr == OFS_DIV_LO);
        hi_wr_ok  = bus_wr && latch_sel && !uart_busy && (bus_addr == OFS_SHARED);
        ie_wr_ok  = bus_wr && !latch_sel && (bus_addr == OFS_SHARED);
        div_wr_ok = lo_wr_ok || hi_wr_ok;
    end

    // Divisor byte storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo <= '0;
            div_hi <= '0;
        end else begin
            if (lo_wr_ok) div_lo <= bus_wdata;
            if (hi_wr_ok) div_hi <= bus_wdata;
        end
    end

    // Interrupt-enable storage; reserved bits never store ones
    always_ff @(posedge clk) begin
        if (!rst_n)        ie_reg <= '0;
        else if (ie_wr_ok) ie_reg <= bus_wdata & IE_WRITABLE;
    end

    assign divisor = {div_hi, div_lo};

    // Read multiplexer, shared offset steered by latch_sel
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_DIV_LO && latch_sel)
            bus_rdata[REG_W-1:0] = div_lo;
        else if (bus_addr == OFS_SHARED)
            bus_rdata[REG_W-1:0] = latch_sel ? div_hi : ie_reg;
    end

    // R3: a busy divisor write must not disturb the divisor
    a_r3_busy_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && uart_busy && latch_sel) |=> $stable(divisor));
    // R8: reserved enable bits never hold a one
    a_r8_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ie_wr_ok |=> ((ie_reg & ~IE_WRITABLE) == '0));
endmodule

// File: rtl/uart_baud_counter.sv
// Module: divide-by-divisor tick generator producing the 16x sampling tick.
// Assumes: reload pulses on every accepted divisor write; zero divisor halts.
module uart_baud_counter
    import uart_baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             reload,
    output logic             tick
);
    logic [DIV_W-1:0] phase;
    logic             at_end;

    assign at_end = (divisor != '0) && (phase >= divisor - DIV_W'(1));
    assign tick   = (divisor != '0) && (phase == divisor - DIV_W'(1));

    // Phase counter: restarts on reload, wraps at divisor-1, idles at zero
    always_ff @(posedge clk) begin
        if (!rst_n || reload || divisor == '0) phase <= '0;
        else if (at_end)                         phase <= '0;
        else                                     phase <= phase + DIV_W'(1);
    end

    // R5: no tick from a zero divisor
    a_r5_zero_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !tick);
    // R4: phase stays inside the divisor range once running
    a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor != '0 && $stable(divisor) && !$past(reload)) |-> (phase < divisor));
    // R9: a reload starts the phase at zero
    a_r9_reload_restart: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (phase == '0));
endmodule

// File: rtl/uart_settle_timer.sv
// Module: holds a not-ready flag for a fixed window after a high-byte write.
// Assumes: start is a single-cycle accepted-write pulse.
module uart_settle_timer
    import uart_baud_pkg::*;
#(
    parameter int WINDOW = SETTLE_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pending
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    logic [CNT_W-1:0] remain;

    // Countdown of settling cycles, restarted by each start pulse
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= '0;
        else if (start)       remain <= CNT_W'(WINDOW);
        else if (remain != 0) remain <= remain - CNT_W'(1);
    end

    assign pending = (remain != '0);

    // R6: flag raised right after start
    a_r6_settle_raised: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pending);
    // R6: window shrinks by one each cycle without a restart
    a_r6_settle_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !start) |=> (remain == $past(remain) - CNT_W'(1)));
endmodule

// File: rtl/uart_baud_regs.sv
// Module: top of the UART divisor/baud slice. Wires register storage, the
// tick generator and the settling timer together.
// Assumes: synchronous active-low reset; the serial clock is clk.
module uart_baud_regs
    import uart_baud_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [RDATA_W-1:0] bus_rdata,
    input  logic               latch_sel,
    input  logic               uart_busy,
    output logic               baud_tick,
    output logic               settle_pending,
    output logic [REG_W-1:0]   irq_en
);
    logic [DIV_W-1:0] divisor;
    logic             div_wr_ok, hi_wr_ok;

    uart_div_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .latch_sel(latch_sel), .uart_busy(uart_busy),
        .divisor(divisor), .ie_reg(irq_en), .div_wr_ok(div_wr_ok),
        .hi_wr_ok(hi_wr_ok), .bus_rdata(bus_rdata)
    );

    uart_baud_counter u_count (
        .clk(clk), .rst_n(rst_n), .divisor(divisor),
        .reload(div_wr_ok), .tick(baud_tick)
    );

    uart_settle_timer #(.WINDOW(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .start(hi_wr_ok), .pending(settle_pending)
    );

    // R1: outputs quiet in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!baud_tick && !settle_pending && irq_en == '0));
endmodule

// File: tb/uart_baud_regs_test.sv
`timescale 1ns/1ps
module uart_baud_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        latch_sel = 1'b0;
    logic        uart_busy = 1'b0;
    logic        baud_tick;
    logic        settle_pending;
    logic [7:0]  irq_en;

    int n_checks = 0;
    int n_fails = 0;
    int tick_count = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_lo = 0, m_hi = 0, m_ie = 0, m_phase = 0, m_settle = 0;

    always #2 clk = ~clk;

    uart_baud_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .latch_sel(latch_sel),
        .uart_busy(uart_busy), .baud_tick(baud_tick),
        .settle_pending(settle_pending), .irq_en(irq_en)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int model_div();
        return m_hi * 256 + m_lo;
    endfunction

    function automatic int model_rdata();
        if (bus_addr == 8'h00 && latch_sel) return m_lo;
        if (bus_addr == 8'h04) return latch_sel ? m_hi : m_ie;
        return 0;
    endfunction

    // Step the model at each edge, then compare outputs 1 ns later
    always @(posedge clk) begin
        int d;
        d = model_div();
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_ie = 0; m_phase = 0; m_settle = 0;
        end else begin
            if (d == 0 || m_phase >= d - 1) m_phase = 0; else m_phase++;
            if (m_settle > 0) m_settle--;
            if (bus_wr && latch_sel && !uart_busy && bus_addr == 8'h00) begin
                m_lo = bus_wdata; m_phase = 0;
            end
            if (bus_wr && latch_sel && !uart_busy && bus_addr == 8'h04) begin
                m_hi = bus_wdata; m_phase = 0; m_settle = 8;
            end
            if (bus_wr && !latch_sel && bus_addr == 8'h04)
                m_ie = bus_wdata & 8'h8F;
        end
        #1;
        d = model_div();
        if (baud_tick) tick_count++;
        check(d == 0 ? "R5" : "R4/R9", "baud_tick", baud_tick, (d != 0 && m_phase == d - 1));
        check("R6", "settle_pending", settle_pending, m_settle > 0);
        check("R7", "irq_en", irq_en, m_ie);
        check("R10", "bus_rdata", bus_rdata, model_rdata());
    end

    task automatic wr(input logic ls, input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        latch_sel = ls; bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset contents through the read port
        latch_sel = 1'b1; bus_addr = 8'h00; #0.5;
        check("R1", "low byte after reset", bus_rdata, 0);
        bus_addr = 8'h04; #0.5;
        check("R1", "high byte after reset", bus_rdata, 0);
        check("R1", "settle after reset", settle_pending, 0);
        idle(4);

        // R2 R4 R9: divisor 3, then divisor 1
        wr(1'b1, 8'h00, 8'd3);
        idle(20);
        wr(1'b1, 8'h00, 8'd1);
        idle(6);

        // R3: busy blocks divisor writes
        uart_busy = 1'b1;
        wr(1'b1, 8'h00, 8'd7);
        wr(1'b1, 8'h04, 8'd2);
        bus_addr = 8'h00; #0.5;
        check("R3", "low byte after busy write", bus_rdata, 1);
        check("R3", "settle after busy write", settle_pending, 0);
        // R3: IER write still accepted while busy
        wr(1'b0, 8'h04, 8'h05);
        #0.5;
        check("R3", "ie written while busy", irq_en, 8'h05);
        uart_busy = 1'b0;

        // R6: high byte write starts settle; restart midway
        wr(1'b1, 8'h04, 8'h00);
        idle(3);
        wr(1'b1, 8'h04, 8'h00);
        idle(12);

        // R5: zero divisor, count ticks
        wr(1'b1, 8'h00, 8'h00);
        tick_count = 0;
        idle(40);
        check("R5", "ticks with zero divisor", tick_count, 0);

        // R7 R8: IER all ones, reserved bits stay clear
        wr(1'b0, 8'h04, 8'hFF);
        latch_sel = 1'b0; bus_addr = 8'h04; #0.5;
        check("R8", "ie readback masked", bus_rdata, 32'h8F);
        check("R7", "ie output", irq_en, 8'h8F);
        // R2: latch_sel 0 write at offset 0 ignored
        wr(1'b0, 8'h00, 8'h55);
        latch_sel = 1'b1; bus_addr = 8'h00; #0.5;
        check("R2", "offset 0 unchanged", bus_rdata, 0);
        // R10: same-cycle steering of the shared offset
        wr(1'b1, 8'h04, 8'h01);
        bus_addr = 8'h04; latch_sel = 1'b1; #0.5;
        check("R10", "shared offset with latch", bus_rdata, 1);
        latch_sel = 1'b0; #0.5;
        check("R10", "shared offset without latch", bus_rdata, 32'h8F);
        bus_addr = 8'h08; #0.5;
        check("R10", "unmapped offset", bus_rdata, 0);

        // R4: divisor 0x0100, count ticks over a long window
        wr(1'b1, 8'h00, 8'h00);
        tick_count = 0;
        idle(256 * 3);
        check("R4", "ticks in 768 cycles at 256", tick_count, 3);
        wr(1'b1, 8'h00, 8'd5);
        idle(30);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule